// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a shared on-chip bus and judges each access issued by one of four bus masters: the processor's instruction fetch port, its data port, a DMA engine and a network controller. It holds sixteen programmable address windows. Each window has a lower and an upper bound, both in 32-byte units, an enable bit, and its own read, write and execute rights for every master. Every access is compared against all sixteen windows in the same cycle. One registered allow/deny verdict comes out one cycle later.

A denied access leaves a record of the master, the full address and the access kind. A sticky flag stays set until software clears it. Software programs the windows through a simple write port that takes a window index, a field selector and a data word. After reset no window is enabled, so nothing is allowed until software sets one up.

Top module: `prot_checker`

## Requirements
- R1: After reset `dec_valid` and `flt_flag` are 0 and every window is disabled, so any access is denied.
- R2: `dec_valid` equals `acc_valid` one clock earlier; `dec_allow` is the verdict for the access presented on that earlier edge and is 0 whenever `dec_valid` is 0.
- R3: A window covers an address when `acc_addr[31:5]` lies between the lower and upper bound fields, both bounds inclusive. Address bits [4:0] play no part.
- R4: Master IDs are 0 instruction port, 1 data port, 2 DMA, 3 network controller. Kinds are 0 read, 1 write, 2 execute, and 3 is reserved and always denied. A covering window allows the access only if its right bit `3*master + kind` is set.
- R5: An access is allowed when at least one enabled window both covers it and grants the right. Overlapping windows are OR-combined.
- R6: A window whose enable bit is 0 never allows anything, even if it still holds rights and bounds.
- R7: On a denied access, `flt_master`, `flt_addr` and `flt_kind` take that access's values and `flt_flag` becomes 1, all on the same edge as the verdict. The flag stays at 1 across later allowed accesses.
- R8: `flt_clr` clears `flt_flag` on the next edge. If a denial happens on that same edge, the denial wins and the flag stays 1.
- R9: Configuration selectors are 0 lower bound (`cfg_wdata[31:5]`), 1 upper bound (`cfg_wdata[31:5]`), 2 attributes (enable in bit 31, rights in bits [11:0]) and 3 no effect. A write is seen only by accesses presented after the edge that stores it, not by an access presented in the same cycle.
- R10: A cycle with `acc_valid` low yields `dec_valid` 0 and leaves the fault record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_master | input | 2 | Requesting master ID |
| acc_addr | input | 32 | Byte address of the access |
| acc_kind | input | 2 | Access kind: read, write, execute, reserved |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | 4 | Window index to write |
| cfg_sel | input | 2 | Field selector |
| cfg_wdata | input | 32 | Configuration data word |
| flt_clr | input | 1 | Clear the sticky fault flag |
| dec_valid | output | 1 | A verdict is present |
| dec_allow | output | 1 | Verdict: 1 allowed, 0 denied |
| flt_flag | output | 1 | Sticky fault indication |
| flt_master | output | 2 | Master of the latest denied access |
| flt_addr | output | 32 | Address of the latest denied access |
| flt_kind | output | 2 | Kind of the latest denied access |

## Verification
The bench checks both inclusive bounds and the first address past each end. A comparator that is off by one would allow the byte beyond the upper limit or reject the byte at the lower one. It also checks that the reserved kind is refused, so a design that indexed the rights with kind 3 would leak the next master's read bit. Two overlapping windows are made, then one is disabled while its rights are kept; a design that ignored the enable bit would still allow the access. Timing corners cover a clear that collides with a denial, where a wrong priority drops the fault flag, and a window enabled in the very cycle it is needed, where a bypass would allow that access early.

// File: rtl/prot_pkg.sv
package prot_pkg;
    localparam int NUM_REGIONS = 16;
    localparam int NUM_MASTERS = 4;
    localparam int ADDR_W      = 32;
    localparam int GRAN_W      = 5;
    localparam int NUM_RIGHTS  = 3;

    localparam int FIELD_W  = ADDR_W - GRAN_W;
    localparam int RIDX_W   = $clog2(NUM_REGIONS);
    localparam int MID_W    = $clog2(NUM_MASTERS);
    localparam int RIGHTS_W = NUM_MASTERS * NUM_RIGHTS;
    localparam int EN_BIT   = ADDR_W - 1;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CFG_LO   = 2'd0,
        CFG_HI   = 2'd1,
        CFG_ATTR = 2'd2,
        CFG_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic                en;
        logic [FIELD_W-1:0]  lo;
        logic [FIELD_W-1:0]  hi;
        logic [RIGHTS_W-1:0] rights;
    } region_t;

    typedef region_t [NUM_REGIONS-1:0] region_tab_t;
endpackage

// File: rtl/prot_region_file.sv
module prot_region_file
    import prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RIDX_W-1:0] cfg_region,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output region_tab_t       tab_o,
    output logic              any_en_o
);
    region_tab_t tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_LO:   tab_d[cfg_region].lo = cfg_wdata[ADDR_W-1:GRAN_W];
                CFG_HI:   tab_d[cfg_region].hi = cfg_wdata[ADDR_W-1:GRAN_W];
                CFG_ATTR: begin
                    tab_d[cfg_region].en     = cfg_wdata[EN_BIT];
                    tab_d[cfg_region].rights = cfg_wdata[RIGHTS_W-1:0];
                end
                default:  tab_d = tab_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    logic [NUM_REGIONS-1:0] en_vec;
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_en
        assign en_vec[r] = tab_q[r].en;
    end
    assign any_en_o = |en_vec;
    assign tab_o    = tab_q;

    // R9
    attr_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == CFG_ATTR) |=>
            tab_q[$past(cfg_region)].en == $past(cfg_wdata[EN_BIT]));

    // R9
    ignored_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we || cfg_sel == CFG_NONE) |=> $stable(tab_q));
endmodule

// File: rtl/prot_match.sv
module prot_match
    import prot_pkg::*;
(
    input  region_tab_t          tab_i,
    input  logic [MID_W-1:0]     master_i,
    input  logic [FIELD_W-1:0]   addr_field_i,
    input  logic [1:0]           kind_i,
    output logic                 allow_o
);
    logic [NUM_REGIONS-1:0] hit_vec;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        logic                  in_range;
        logic [NUM_RIGHTS-1:0] rset;
        logic                  granted;

        assign in_range = (addr_field_i >= tab_i[r].lo) &&
                          (addr_field_i <= tab_i[r].hi);
        assign rset     = tab_i[r].rights[int'(master_i)*NUM_RIGHTS +: NUM_RIGHTS];
        assign granted  = (acc_kind_e'(kind_i) == ACC_RSVD) ? 1'b0 : rset[kind_i];
        assign hit_vec[r] = tab_i[r].en && in_range && granted;
    end

    assign allow_o = |hit_vec;
endmodule

// File: rtl/prot_fault.sv
module prot_fault
    import prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deny_i,
    input  logic              clr_i,
    input  logic [MID_W-1:0]  master_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        kind_i,
    output logic              flag_o,
    output logic [MID_W-1:0]  master_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        kind_o
);
    typedef struct packed {
        logic              flag;
        logic [MID_W-1:0]  master;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        kind;
    } fault_t;

    fault_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (clr_i) flt_d.flag = 1'b0;
        if (deny_i) begin
            flt_d.flag   = 1'b1;
            flt_d.master = master_i;
            flt_d.addr   = addr_i;
            flt_d.kind   = kind_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign flag_o   = flt_q.flag;
    assign master_o = flt_q.master;
    assign addr_o   = flt_q.addr;
    assign kind_o   = flt_q.kind;

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.flag && !clr_i) |=> flt_q.flag);

    // R8
    deny_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deny_i && clr_i) |=> flt_q.flag);

    // R10
    record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !deny_i |=> ($stable(flt_q.addr) && $stable(flt_q.master) && $stable(flt_q.kind)));
endmodule

// File: rtl/prot_checker.sv
module prot_checker
    import prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [MID_W-1:0]  acc_master,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              cfg_we,
    input  logic [RIDX_W-1:0] cfg_region,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              flt_clr,
    output logic              dec_valid,
    output logic              dec_allow,
    output logic              flt_flag,
    output logic [MID_W-1:0]  flt_master,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [1:0]        flt_kind
);
    typedef struct packed {
        logic valid;
        logic allow;
    } dec_t;

    region_tab_t tab;
    logic        any_en;
    logic        match_allow;
    logic        deny;
    dec_t        dec_d, dec_q;

    prot_region_file u_regions (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_region (cfg_region),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .tab_o      (tab),
        .any_en_o   (any_en)
    );

    prot_match u_match (
        .tab_i        (tab),
        .master_i     (acc_master),
        .addr_field_i (acc_addr[ADDR_W-1:GRAN_W]),
        .kind_i       (acc_kind),
        .allow_o      (match_allow)
    );

    always_comb begin
        dec_d       = dec_q;
        dec_d.valid = acc_valid;
        dec_d.allow = acc_valid && match_allow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign deny = acc_valid && !match_allow;

    prot_fault u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .deny_i   (deny),
        .clr_i    (flt_clr),
        .master_i (acc_master),
        .addr_i   (acc_addr),
        .kind_i   (acc_kind),
        .flag_o   (flt_flag),
        .master_o (flt_master),
        .addr_o   (flt_addr),
        .kind_o   (flt_kind)
    );

    assign dec_valid = dec_q.valid;
    assign dec_allow = dec_q.allow;

    // R2
    verdict_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> dec_valid);

    // R2
    allow_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_allow |-> dec_valid);

    // R1
    allow_needs_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !any_en) |=> !dec_allow);

    // R4
    rsvd_kind_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == ACC_RSVD) |=> (dec_valid && !dec_allow));

    // R7
    deny_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_allow) |-> (flt_flag && flt_addr == $past(acc_addr)
                                       && flt_master == $past(acc_master)));
endmodule

// File: tb/prot_checker_tb.sv
module prot_checker_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_master = '0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_region = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        flt_clr = 1'b0;
    logic        dec_valid, dec_allow, flt_flag;
    logic [1:0]  flt_master, flt_kind;
    logic [31:0] flt_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        m_en [16];
    logic [26:0] m_lo [16];
    logic [26:0] m_hi [16];
    logic [11:0] m_rights [16];
    logic        m_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_checker dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_master(acc_master),
        .acc_addr(acc_addr), .acc_kind(acc_kind),
        .cfg_we(cfg_we), .cfg_region(cfg_region),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .flt_clr(flt_clr),
        .dec_valid(dec_valid), .dec_allow(dec_allow), .flt_flag(flt_flag),
        .flt_master(flt_master), .flt_addr(flt_addr), .flt_kind(flt_kind)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_allow(int m, logic [31:0] a, int k);
        for (int r = 0; r < 16; r++)
            if (m_en[r] && a[31:5] >= m_lo[r] && a[31:5] <= m_hi[r] &&
                k < 3 && m_rights[r][m*3+k])
                return 1'b1;
        return 1'b0;
    endfunction

    function automatic void model_cfg(int r, int sel, logic [31:0] d);
        case (sel)
            0: m_lo[r] = d[31:5];
            1: m_hi[r] = d[31:5];
            2: begin m_en[r] = d[31]; m_rights[r] = d[11:0]; end
            default: ;
        endcase
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic cfg_wr(int r, int sel, logic [31:0] d);
        cfg_we = 1'b1; cfg_region = 4'(r); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_cfg(r, sel, d);
    endtask

    task automatic access_full(int m, logic [31:0] a, int k, bit clr,
                               bit cw, int cr, int cs, logic [31:0] cd, string req);
        logic e;
        e = exp_allow(m, a, k);
        acc_valid = 1'b1; acc_master = 2'(m); acc_addr = a; acc_kind = 2'(k);
        flt_clr = clr;
        cfg_we = cw; cfg_region = 4'(cr); cfg_sel = 2'(cs); cfg_wdata = cd;
        @(negedge clk);
        acc_valid = 1'b0; flt_clr = 1'b0; cfg_we = 1'b0;
        if (cw) model_cfg(cr, cs, cd);
        if (clr) m_flag = 1'b0;
        if (!e) m_flag = 1'b1;
        chk("R2 dec_valid", 64'(dec_valid), 64'(1));
        chk(req, 64'(dec_allow), 64'(e));
        chk("R7/R8 flt_flag", 64'(flt_flag), 64'(m_flag));
        if (!e) begin
            chk("R7 flt_addr", 64'(flt_addr), 64'(a));
            chk("R7 flt_master", 64'(flt_master), 64'(m));
            chk("R7 flt_kind", 64'(flt_kind), 64'(k));
        end
    endtask

    task automatic access(int m, logic [31:0] a, int k, string req);
        access_full(m, a, k, 1'b0, 1'b0, 0, 0, 32'h0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] saved;
        void'($urandom(32'h5eed_0042));
        for (int r = 0; r < 16; r++) begin
            m_en[r] = 0; m_lo[r] = '0; m_hi[r] = '0; m_rights[r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and default denial
        chk("R1 dec_valid after reset", 64'(dec_valid), 64'(0));
        chk("R1 flt_flag after reset", 64'(flt_flag), 64'(0));
        access(1, 32'h0000_0040, 0, "R1 deny with no window");

        // Window 0: 0x2000_0000..0x2000_00FF, data port read/write, fetch exec
        cfg_wr(0, 0, 32'h2000_0000);
        cfg_wr(0, 1, 32'h2000_00E0);
        cfg_wr(0, 2, 32'h8000_0000 | 12'b000_000_011_100);
        access(1, 32'h2000_0000, 0, "R3 lower bound inclusive");
        access(1, 32'h2000_00FF, 0, "R3 upper bound incl low bits");
        access(1, 32'h2000_0100, 0, "R3 just above upper");
        access(1, 32'h1FFF_FFFF, 1, "R3 just below lower");
        access(1, 32'h2000_0080, 1, "R4 data write granted");
        access(1, 32'h2000_0080, 2, "R4 data exec not granted");
        access(0, 32'h2000_0010, 2, "R4 fetch exec granted");
        access(2, 32'h2000_0010, 0, "R4 dma read not granted");
        access(1, 32'h2000_0010, 3, "R4 reserved kind denied");

        // Window 5 overlaps window 0, gives DMA read
        cfg_wr(5, 0, 32'h2000_0040);
        cfg_wr(5, 1, 32'h2000_0040);
        cfg_wr(5, 2, 32'h8000_0000 | 12'b000_001_000_000);
        access(2, 32'h2000_0044, 0, "R5 overlap grants dma");
        access(1, 32'h2000_0044, 1, "R5 overlap keeps data write");
        cfg_wr(5, 2, 32'h0000_0000 | 12'b000_001_000_000);
        access(2, 32'h2000_0044, 0, "R6 disabled window no match");
        cfg_wr(5, 3, 32'hFFFF_FFFF);
        access(2, 32'h2000_0044, 0, "R9 selector 3 no effect");

        // R10 idle cycle leaves record alone
        saved = flt_addr;
        @(negedge clk);
        chk("R10 dec_valid idle", 64'(dec_valid), 64'(0));
        chk("R10 record held", 64'(flt_addr), 64'(saved));

        // R8 clear alone, then clear colliding with a denial
        flt_clr = 1'b1;
        @(negedge clk);
        flt_clr = 1'b0; m_flag = 1'b0;
        chk("R8 clear drops flag", 64'(flt_flag), 64'(0));
        access_full(3, 32'h3000_0000, 0, 1'b1, 1'b0, 0, 0, 32'h0, "R8 deny with clear");
        access_full(1, 32'h2000_0000, 0, 1'b1, 1'b0, 0, 0, 32'h0, "R8 clear on allow");

        // R9 enable in same cycle as the access: old table applies
        access_full(2, 32'h2000_0044, 0, 1'b0, 1'b1, 5, 2,
                    32'h8000_0000 | 12'b000_001_000_000, "R9 same cycle not seen");
        access(2, 32'h2000_0044, 0, "R9 next cycle seen");

        // Random windows and accesses
        for (int i = 0; i < 6; i++) begin
            logic [31:0] base;
            base = 32'h1000_0000 + ($urandom % 32'h4000);
            cfg_wr(8 + i, 0, base);
            cfg_wr(8 + i, 1, base + 32'(($urandom % 64) << 5));
            cfg_wr(8 + i, 2, {1'b1, 19'h0, 12'($urandom)});
        end
        for (int i = 0; i < 300; i++) begin
            access_full(int'($urandom % 4), 32'h1000_0000 + ($urandom % 32'h5000),
                        int'($urandom % 4), ($urandom % 8) == 0,
                        1'b0, 0, 0, 32'h0, "R5 random verdict");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule